// File: doc/BRIEF.md
# Delegated Counter Alias Access Decoder

This block sits beside the supervisor indirect-register window. When software reads or writes one of the six window data aliases while the window select holds an index reserved for counters, the block decides whether the access may go ahead. If it may, the block names which counter is meant and which half of which register of that counter the alias stands for. If it may not, it names the exception to raise, either illegal instruction or virtual instruction. The decision depends on the privilege mode, the virtualization flag, whether the guest-bank aliases were named directly, the machine-level delegation enable, the per-counter delegation mask, the register width and the set of implemented counter features.

For writes that target an event selector or counter configuration register, the block produces a filtered write mask and write data, so the machine-only inhibit bit is never changed through the alias. For reads it masks the raw register value in the same way. The counter storage, interrupt delivery and the state-enable controls lie outside the block. The state-enable result arrives as one gate input.

Every result is registered, one clock cycle after the request.

Top module: `dctr_alias_ctl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every output is 0.
- R2: A cycle with neither `req_rd` nor `req_wr` gives, one cycle later, `hit`=0, `grant`=0, `exc`=0 (none), `wr_en`=0 and zero data outputs.
- R3: A request with `gate_ok`=0 gives `exc`=1 (illegal) and no grant, whatever the mode, index or alias. No other rule is evaluated.
- R4: `hit` is 1 only for a request whose `sel_idx` lies in 0x40..0x5F. A request outside that range gives no grant and no exception.
- R5: In M mode, or in S mode with `virt`=0, a request in range with `deleg_en`=0 gives `exc`=1.
- R6: In M or non-virtual S mode, `alias_num` values 0, 3, 6 and 7 give `exc`=1. Values 4 and 5 (upper halves) give `exc`=1 when `xlen64`=1.
- R7: In M or non-virtual S mode, index 0x41 (the timer) always gives `exc`=1. An index 0x40+i whose `deleg_mask[i]`=0 also gives `exc`=1.
- R8: `feat` bit 0 backs counter aliases 1/4 for indices 0 and 2. Bit 1 backs every alias for indices 3..31. Bit 2 backs selector aliases 2/5 for indices 0 and 2. Bit 3 is also needed for alias 5 at indices 3..31. A needed bit that is 0 gives `exc`=1 in M or S mode.
- R9: With `priv`=1 and `virt`=1 (VS), a request gives `exc`=2 (virtual) if `vs_bank`=1. Otherwise it gives `exc`=1 when `deleg_en`=0 and `exc`=2 when it is 1. With `priv`=0 and `virt`=1 (VU) it gives `exc`=2. With `priv`=0 and `virt`=0 it gives `exc`=1. In M or S mode, `vs_bank`=1 gives `exc`=1.
- R10: A granted access gives `ctr_idx` = `sel_idx`-0x40. It gives `target` 0 for alias 1 (counter low), 1 for alias 4 (counter high), 2 for alias 2 (selector low) and 3 for alias 5 (selector high).
- R11: A granted write raises `wr_en`. `wmask_o` is all ones, except that bits 63..32 are 0 when `xlen64`=0. Bit 62 is also 0 for target 2 when `xlen64`=1, and bit 30 is 0 for target 3 when `xlen64`=0. `wdata_o` is `wdata_i` AND `wmask_o`. With no granted write, all three are 0.
- R12: A granted read gives `rdata_o` = `rdata_raw` AND the mask of R11. Any other cycle gives 0.
- R13: Each decision appears on the outputs exactly one clock edge after the request inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read of a window data alias |
| req_wr | input | 1 | Write of a window data alias |
| priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Virtualization active |
| vs_bank | input | 1 | The guest-bank aliases are named directly |
| gate_ok | input | 1 | State-enable gate permits window access |
| sel_idx | input | 12 | Current window select value |
| alias_num | input | 3 | Data alias number, 1..6 |
| deleg_en | input | 1 | Machine counter delegation enable |
| deleg_mask | input | 32 | Per-counter delegation bits |
| xlen64 | input | 1 | 1 for 64-bit registers, 0 for 32-bit |
| feat | input | 4 | Implemented counter features (see R8) |
| wdata_i | input | 64 | Write data from software |
| rdata_raw | input | 64 | Raw value of the addressed register |
| hit | output | 1 | Request fell inside the counter window |
| grant | output | 1 | Access allowed |
| exc | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |
| ctr_idx | output | 5 | Resolved counter index |
| target | output | 2 | Aliased register half |
| wr_en | output | 1 | Write allowed to the target |
| wdata_o | output | 64 | Filtered write data |
| wmask_o | output | 64 | Bits the write may change |
| rdata_o | output | 64 | Filtered read data |

## Verification
The block holds no state except its output registers, so a wrong decision shows on the ports at the very next clock edge. That decision can be a flipped rule, a wrong window offset or a lost mask bit, and it appears as a wrong `exc` code, a wrong `grant`, a shifted `ctr_idx` or an inhibit bit that leaks through `wmask_o` or `rdata_o`. Precedence faults matter most, such as the gate being checked after the mode, or a VS request taking the machine path. The mode and enable sweep brings them out because it pairs every mode with every alias, boundary index, enable and width.

// File: rtl/dctr_pkg.sv
package dctr_pkg;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_ILL  = 2'd1,
        EXC_VIRT = 2'd2
    } exc_e;

    typedef enum logic [1:0] {
        TGT_CTR_LO = 2'd0,
        TGT_CTR_HI = 2'd1,
        TGT_SEL_LO = 2'd2,
        TGT_SEL_HI = 2'd3
    } tgt_e;

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    localparam int FEAT_W  = 4;
    localparam int FT_FIXED = 0;
    localparam int FT_PROG  = 1;
    localparam int FT_CFG   = 2;
    localparam int FT_OVF   = 3;

    typedef struct packed {
        logic ok;
        logic upper;
        tgt_e tgt;
    } alias_t;

    typedef struct packed {
        logic hit;
        logic grant;
        exc_e exc;
        tgt_e tgt;
    } verdict_t;

    function automatic alias_t decode_alias(input logic [2:0] num);
        alias_t r;
        r.ok    = 1'b1;
        r.upper = 1'b0;
        r.tgt   = TGT_CTR_LO;
        case (num)
            3'd1: r.tgt = TGT_CTR_LO;
            3'd2: r.tgt = TGT_SEL_LO;
            3'd4: begin r.tgt = TGT_CTR_HI; r.upper = 1'b1; end
            3'd5: begin r.tgt = TGT_SEL_HI; r.upper = 1'b1; end
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dctr_window.sv
module dctr_window #(
    parameter int SEL_W    = 12,
    parameter int SEL_BASE = 'h40,
    parameter int NUM_CTR  = 32,
    parameter int IDX_W    = 5
) (
    input  logic [SEL_W-1:0] sel,
    output logic             in_win,
    output logic [IDX_W-1:0] idx
);
    localparam logic [SEL_W-1:0] LO = SEL_W'(SEL_BASE);
    localparam logic [SEL_W-1:0] HI = SEL_W'(SEL_BASE + NUM_CTR);

    always_comb begin
        in_win = (sel >= LO) && (sel < HI);
        idx    = IDX_W'(sel - LO);
    end
endmodule

// File: rtl/dctr_feat.sv
module dctr_feat
    import dctr_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int FIXED_CNT = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  tgt_e              tgt,
    input  logic [FEAT_W-1:0] feat,
    output logic              feat_ok
);
    logic fixed;

    always_comb begin
        fixed = (idx < IDX_W'(FIXED_CNT));
        unique case (tgt)
            TGT_CTR_LO, TGT_CTR_HI: feat_ok = fixed ? feat[FT_FIXED] : feat[FT_PROG];
            TGT_SEL_LO:             feat_ok = fixed ? feat[FT_CFG]   : feat[FT_PROG];
            TGT_SEL_HI:             feat_ok = fixed ? feat[FT_CFG]
                                                    : (feat[FT_PROG] & feat[FT_OVF]);
            default:                feat_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dctr_rules.sv
module dctr_rules
    import dctr_pkg::*;
#(
    parameter int NUM_CTR   = 32,
    parameter int IDX_W     = 5,
    parameter int TIMER_IDX = 1
) (
    input  logic               req,
    input  logic               gate_ok,
    input  logic               in_win,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               vs_bank,
    input  logic               deleg_en,
    input  logic [NUM_CTR-1:0] deleg_mask,
    input  logic [IDX_W-1:0]   idx,
    input  alias_t             al,
    input  logic               xlen64,
    input  logic               feat_ok,
    output exc_e               exc,
    output logic               grant
);
    logic host_bad;

    always_comb begin
        host_bad = vs_bank
                 | ~deleg_en
                 | ~al.ok
                 | (al.upper & xlen64)
                 | (idx == IDX_W'(TIMER_IDX))
                 | ~deleg_mask[idx]
                 | ~feat_ok;

        exc   = EXC_NONE;
        grant = 1'b0;
        if (req) begin
            if (!gate_ok) begin
                exc = EXC_ILL;
            end else if (in_win) begin
                unique case (priv)
                    PRV_M: begin
                        if (host_bad) exc = EXC_ILL;
                        else          grant = 1'b1;
                    end
                    PRV_S: begin
                        if (virt) begin
                            if (vs_bank || deleg_en) exc = EXC_VIRT;
                            else                     exc = EXC_ILL;
                        end else if (host_bad) begin
                            exc = EXC_ILL;
                        end else begin
                            grant = 1'b1;
                        end
                    end
                    PRV_U:   exc = virt ? EXC_VIRT : EXC_ILL;
                    default: exc = EXC_ILL;
                endcase
            end
        end
    end
endmodule

// File: rtl/dctr_filter.sv
module dctr_filter
    import dctr_pkg::*;
#(
    parameter int DW       = 64,
    parameter int MINH_BIT = 62
) (
    input  tgt_e          tgt,
    input  logic          xlen64,
    input  logic          grant,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] rdata_raw,
    output logic          wr_en,
    output logic [DW-1:0] wmask,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o
);
    localparam int HALF    = DW / 2;
    localparam int MINH_HI = MINH_BIT - HALF;

    logic [DW-1:0] keep;

    always_comb begin
        keep = '1;
        if (!xlen64) keep[DW-1:HALF] = '0;
        if (tgt == TGT_SEL_LO && xlen64)  keep[MINH_BIT] = 1'b0;
        if (tgt == TGT_SEL_HI && !xlen64) keep[MINH_HI]  = 1'b0;

        wr_en   = grant & wr;
        wmask   = wr_en ? keep : '0;
        wdata_o = wr_en ? (wdata_i & keep) : '0;
        rdata_o = (grant & rd) ? (rdata_raw & keep) : '0;
    end
endmodule

// File: rtl/dctr_alias_ctl.sv
module dctr_alias_ctl
    import dctr_pkg::*;
#(
    parameter int SEL_W     = 12,
    parameter int SEL_BASE  = 'h40,
    parameter int NUM_CTR   = 32,
    parameter int TIMER_IDX = 1,
    parameter int FIXED_CNT = 3,
    parameter int DW        = 64,
    parameter int MINH_BIT  = 62,
    localparam int IDX_W    = $clog2(NUM_CTR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_rd,
    input  logic               req_wr,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               vs_bank,
    input  logic               gate_ok,
    input  logic [SEL_W-1:0]   sel_idx,
    input  logic [2:0]         alias_num,
    input  logic               deleg_en,
    input  logic [NUM_CTR-1:0] deleg_mask,
    input  logic               xlen64,
    input  logic [FEAT_W-1:0]  feat,
    input  logic [DW-1:0]      wdata_i,
    input  logic [DW-1:0]      rdata_raw,
    output logic               hit,
    output logic               grant,
    output logic [1:0]         exc,
    output logic [IDX_W-1:0]   ctr_idx,
    output logic [1:0]         target,
    output logic               wr_en,
    output logic [DW-1:0]      wdata_o,
    output logic [DW-1:0]      wmask_o,
    output logic [DW-1:0]      rdata_o
);
    logic             req;
    logic             in_win;
    logic [IDX_W-1:0] idx;
    alias_t           al;
    logic             feat_ok;
    exc_e             exc_d;
    logic             grant_d;
    logic             wr_en_d;
    logic [DW-1:0]    wmask_d, wdata_d, rdata_d;
    verdict_t         v_d, v_q;

    assign req = req_rd | req_wr;
    assign al  = decode_alias(alias_num);

    dctr_window #(
        .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .NUM_CTR(NUM_CTR), .IDX_W(IDX_W)
    ) u_win (
        .sel(sel_idx), .in_win(in_win), .idx(idx)
    );

    dctr_feat #(
        .IDX_W(IDX_W), .FIXED_CNT(FIXED_CNT)
    ) u_feat (
        .idx(idx), .tgt(al.tgt), .feat(feat), .feat_ok(feat_ok)
    );

    dctr_rules #(
        .NUM_CTR(NUM_CTR), .IDX_W(IDX_W), .TIMER_IDX(TIMER_IDX)
    ) u_rules (
        .req(req), .gate_ok(gate_ok), .in_win(in_win), .priv(priv),
        .virt(virt), .vs_bank(vs_bank), .deleg_en(deleg_en),
        .deleg_mask(deleg_mask), .idx(idx), .al(al), .xlen64(xlen64),
        .feat_ok(feat_ok), .exc(exc_d), .grant(grant_d)
    );

    dctr_filter #(
        .DW(DW), .MINH_BIT(MINH_BIT)
    ) u_filt (
        .tgt(al.tgt), .xlen64(xlen64), .grant(grant_d), .rd(req_rd),
        .wr(req_wr), .wdata_i(wdata_i), .rdata_raw(rdata_raw),
        .wr_en(wr_en_d), .wmask(wmask_d), .wdata_o(wdata_d), .rdata_o(rdata_d)
    );

    always_comb begin
        v_d.hit   = req & in_win;
        v_d.grant = grant_d;
        v_d.exc   = exc_d;
        v_d.tgt   = al.tgt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q     <= '0;
            ctr_idx <= '0;
            wr_en   <= 1'b0;
            wmask_o <= '0;
            wdata_o <= '0;
            rdata_o <= '0;
        end else begin
            v_q     <= v_d;
            ctr_idx <= req ? idx : '0;
            wr_en   <= wr_en_d;
            wmask_o <= wmask_d;
            wdata_o <= wdata_d;
            rdata_o <= rdata_d;
        end
    end

    assign hit    = v_q.hit;
    assign grant  = v_q.grant;
    assign exc    = v_q.exc;
    assign target = v_q.tgt;
endmodule

// File: rtl/dctr_alias_chk.sv
module dctr_alias_chk
    import dctr_pkg::*;
#(
    parameter int SEL_W     = 12,
    parameter int SEL_BASE  = 'h40,
    parameter int NUM_CTR   = 32,
    parameter int TIMER_IDX = 1,
    parameter int DW        = 64,
    parameter int MINH_BIT  = 62,
    localparam int IDX_W    = $clog2(NUM_CTR)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_rd,
    input logic             req_wr,
    input logic [1:0]       priv,
    input logic             virt,
    input logic             gate_ok,
    input logic [SEL_W-1:0] sel_idx,
    input logic             deleg_en,
    input logic             xlen64,
    input logic             hit,
    input logic             grant,
    input logic [1:0]       exc,
    input logic [IDX_W-1:0] ctr_idx,
    input logic [1:0]       target,
    input logic             wr_en,
    input logic [DW-1:0]    wmask_o
);
    logic req, win;
    assign req = req_rd | req_wr;
    assign win = (sel_idx >= SEL_W'(SEL_BASE)) && (sel_idx < SEL_W'(SEL_BASE + NUM_CTR));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!grant && exc == EXC_NONE && !wr_en));

    // R2
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (exc == EXC_NONE));

    // R3
    gate_block_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !gate_ok) |=> (exc == EXC_ILL && !grant));

    // R4
    miss_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> !grant);

    // R5
    cde_off_chk: assert property (@(posedge clk) disable iff (rst)
        (req && gate_ok && win && priv == PRV_M && !deleg_en) |=> (exc == EXC_ILL));

    // R7
    timer_never_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (ctr_idx != IDX_W'(TIMER_IDX)));

    // R9
    vu_virt_chk: assert property (@(posedge clk) disable iff (rst)
        (req && gate_ok && win && priv == PRV_U && virt) |=> (exc == EXC_VIRT));

    // R11
    minh_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && target == TGT_SEL_LO && $past(xlen64)) |-> !wmask_o[MINH_BIT]);

    // R13
    wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(req_wr));
endmodule

bind dctr_alias_ctl dctr_alias_chk #(
    .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .NUM_CTR(NUM_CTR),
    .TIMER_IDX(TIMER_IDX), .DW(DW), .MINH_BIT(MINH_BIT)
) u_chk (.*);

// File: tb/sim_dctr_alias_ctl.sv
`timescale 1ns/1ps
module sim_dctr_alias_ctl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, rd, wr, virt, vb, gate, cde, x64;
    logic [1:0]  pr;
    logic [11:0] sel;
    logic [2:0]  al;
    logic [31:0] mask;
    logic [3:0]  feat;
    logic [63:0] wd, rr;

    logic        hit, grant, wr_en;
    logic [1:0]  exc, tgt;
    logic [4:0]  idx;
    logic [63:0] wdo, wmo, rdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    dctr_alias_ctl u0 (
        .clk(clk), .rst(rst), .req_rd(rd), .req_wr(wr), .priv(pr), .virt(virt),
        .vs_bank(vb), .gate_ok(gate), .sel_idx(sel), .alias_num(al),
        .deleg_en(cde), .deleg_mask(mask), .xlen64(x64), .feat(feat),
        .wdata_i(wd), .rdata_raw(rr), .hit(hit), .grant(grant), .exc(exc),
        .ctr_idx(idx), .target(tgt), .wr_en(wr_en), .wdata_o(wdo),
        .wmask_o(wmo), .rdata_o(rdo)
    );

    typedef struct packed {
        logic [1:0] pr;
        logic       vt;
        logic       vb;
        logic [7:0] sel;
        logic [2:0] al;
        logic       cde;
        logic       x64;
        logic       eg;
        logic [1:0] ee;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{2'd3, 1'b0, 1'b0, 8'h40, 3'd1, 1'b1, 1'b1, 1'b1, 2'd0},
        '{2'd1, 1'b0, 1'b0, 8'h42, 3'd4, 1'b1, 1'b0, 1'b1, 2'd0},
        '{2'd1, 1'b0, 1'b0, 8'h42, 3'd4, 1'b1, 1'b1, 1'b0, 2'd1},
        '{2'd1, 1'b0, 1'b0, 8'h41, 3'd1, 1'b1, 1'b1, 1'b0, 2'd1},
        '{2'd1, 1'b0, 1'b0, 8'h45, 3'd1, 1'b1, 1'b1, 1'b0, 2'd1},
        '{2'd1, 1'b1, 1'b0, 8'h43, 3'd2, 1'b1, 1'b1, 1'b0, 2'd2},
        '{2'd1, 1'b1, 1'b0, 8'h43, 3'd2, 1'b0, 1'b1, 1'b0, 2'd1},
        '{2'd0, 1'b1, 1'b0, 8'h43, 3'd1, 1'b1, 1'b1, 1'b0, 2'd2},
        '{2'd3, 1'b0, 1'b0, 8'h43, 3'd3, 1'b1, 1'b1, 1'b0, 2'd1},
        '{2'd1, 1'b1, 1'b1, 8'h43, 3'd1, 1'b0, 1'b1, 1'b0, 2'd2},
        '{2'd3, 1'b0, 1'b1, 8'h43, 3'd1, 1'b1, 1'b1, 1'b0, 2'd1},
        '{2'd0, 1'b0, 1'b0, 8'h43, 3'd1, 1'b1, 1'b1, 1'b0, 2'd1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic defaults();
        rd = 1'b1; wr = 1'b0; pr = 2'd3; virt = 1'b0; vb = 1'b0; gate = 1'b1;
        sel = 12'h40; al = 3'd1; cde = 1'b1; x64 = 1'b1;
        mask = 32'hFFFF_FFDF; feat = 4'hF;
        wd = 64'hFFFF_FFFF_FFFF_FFFF; rr = 64'hFFFF_FFFF_FFFF_FFFF;
    endtask

    // Reference model built from the requirements: {hit, grant, exc[1:0], tgt[1:0]}
    function automatic logic [5:0] model();
        logic       inw, any, host_bad, need;
        logic [1:0] e, t;
        int         i;
        bit         fx;
        any = rd | wr;
        inw = (sel >= 12'h40) && (sel <= 12'h5F);
        i   = int'(sel) - 'h40;
        fx  = (i >= 0) && (i < 3);
        t   = (al == 3'd4) ? 2'd1 : (al == 3'd2) ? 2'd2 : (al == 3'd5) ? 2'd3 : 2'd0;
        if (al == 3'd1 || al == 3'd4)      need = fx ? feat[0] : feat[1];
        else if (al == 3'd2)               need = fx ? feat[2] : feat[1];
        else                               need = fx ? feat[2] : (feat[1] & feat[3]);
        host_bad = vb || !cde || !(al == 3'd1 || al == 3'd2 || al == 3'd4 || al == 3'd5)
                || ((al == 3'd4 || al == 3'd5) && x64) || (i == 1)
                || (inw && !mask[i[4:0]]) || !need;
        e = 2'd0;
        if (!any)                       e = 2'd0;
        else if (!gate)                 e = 2'd1;
        else if (!inw)                  e = 2'd0;
        else if (pr == 2'd0)            e = virt ? 2'd2 : 2'd1;
        else if (pr == 2'd1 && virt)    e = (vb || cde) ? 2'd2 : 2'd1;
        else if (pr == 2'd2)            e = 2'd1;
        else                            e = host_bad ? 2'd1 : 2'd0;
        return {any && inw, any && gate && inw && e == 2'd0, e, t};
    endfunction

    initial begin
        defaults();
        rst = 1'b1;
        step();
        // R1: outputs zero in reset despite an active request
        chk("R1 grant in reset", {63'd0, grant}, 64'd0);
        chk("R1 exc in reset", {62'd0, exc}, 64'd0);
        chk("R1 data in reset", wmo | rdo | wdo, 64'd0);
        rst = 1'b0;
        rd = 1'b0;
        step();
        // R2: idle request
        chk("R2 idle grant", {63'd0, grant}, 64'd0);
        chk("R2 idle exc", {62'd0, exc}, 64'd0);
        chk("R2 idle hit", {63'd0, hit}, 64'd0);

        // Table of directed vectors: R5 R6 R7 R9 R10
        foreach (TBL[k]) begin
            defaults();
            pr = TBL[k].pr; virt = TBL[k].vt; vb = TBL[k].vb; sel = {4'd0, TBL[k].sel};
            al = TBL[k].al; cde = TBL[k].cde; x64 = TBL[k].x64;
            step();
            chk($sformatf("R9 R6 R7 table %0d grant", k), {63'd0, grant}, {63'd0, TBL[k].eg});
            chk($sformatf("R5 R9 table %0d exc", k), {62'd0, exc}, {62'd0, TBL[k].ee});
        end

        // Sweep of modes, indices, aliases, enable and width
        for (int m = 0; m < 5; m++) begin
            for (int s = 0; s < 7; s++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int x = 0; x < 2; x++) begin
                            logic [11:0] sl [7];
                            logic [5:0]  ev;
                            sl = '{12'h3F, 12'h40, 12'h41, 12'h42, 12'h45, 12'h5F, 12'h60};
                            defaults();
                            case (m)
                                0: begin pr = 2'd3; virt = 1'b0; end
                                1: begin pr = 2'd1; virt = 1'b0; end
                                2: begin pr = 2'd0; virt = 1'b0; end
                                3: begin pr = 2'd1; virt = 1'b1; end
                                default: begin pr = 2'd0; virt = 1'b1; end
                            endcase
                            sel = sl[s]; al = 3'(a); cde = c[0]; x64 = x[0];
                            ev = model();
                            step();
                            chk("sweep R4 R5 R6 R7 R9 verdict", {60'd0, hit, grant, exc},
                                {60'd0, ev[5:2]});
                            if (ev[4])
                                chk("sweep R10 index/target", {57'd0, idx, tgt},
                                    {57'd0, 5'(sel - 12'h40), ev[1:0]});
                        end
                    end
                end
            end
        end

        // R3: gate blocks even out of the window and in VU mode
        defaults(); gate = 1'b0; sel = 12'h90; step();
        chk("R3 gate off out of window", {62'd0, exc}, 64'd1);
        defaults(); gate = 1'b0; pr = 2'd0; virt = 1'b1; step();
        chk("R3 gate off VU", {62'd0, exc}, 64'd1);

        // R4: outside the window
        defaults(); sel = 12'h60; step();
        chk("R4 above window hit", {62'd0, hit, grant}, 64'd0);
        chk("R4 above window exc", {62'd0, exc}, 64'd0);

        // R8: feature dependencies
        defaults(); feat = 4'b1110; sel = 12'h40; al = 3'd1; step();
        chk("R8 fixed counter no feature", {62'd0, exc}, 64'd1);
        defaults(); feat = 4'b1101; sel = 12'h43; al = 3'd1; step();
        chk("R8 programmable counter no feature", {62'd0, exc}, 64'd1);
        defaults(); feat = 4'b1011; sel = 12'h42; al = 3'd2; step();
        chk("R8 fixed config no feature", {62'd0, exc}, 64'd1);
        defaults(); feat = 4'b0111; sel = 12'h43; al = 3'd5; x64 = 1'b0; step();
        chk("R8 upper selector no overflow feature", {62'd0, exc}, 64'd1);
        defaults(); feat = 4'b1010; sel = 12'h43; al = 3'd5; x64 = 1'b0; step();
        chk("R8 upper selector with features", {63'd0, grant}, 64'd1);

        // R11: write filtering
        defaults(); rd = 1'b0; wr = 1'b1; sel = 12'h43; al = 3'd2; step();
        chk("R11 sel low rv64 wr_en", {63'd0, wr_en}, 64'd1);
        chk("R11 sel low rv64 mask", wmo, 64'hBFFF_FFFF_FFFF_FFFF);
        chk("R11 sel low rv64 data", wdo, 64'hBFFF_FFFF_FFFF_FFFF);
        defaults(); rd = 1'b0; wr = 1'b1; sel = 12'h43; al = 3'd5; x64 = 1'b0; step();
        chk("R11 sel high rv32 mask", wmo, 64'h0000_0000_BFFF_FFFF);
        defaults(); rd = 1'b0; wr = 1'b1; sel = 12'h44; al = 3'd1; wd = 64'h1234_5678_9ABC_DEF0; step();
        chk("R11 counter rv64 mask", wmo, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R11 counter rv64 data", wdo, 64'h1234_5678_9ABC_DEF0);
        defaults(); rd = 1'b0; wr = 1'b1; cde = 1'b0; step();
        chk("R11 denied write", {wmo | wdo}, 64'd0);
        chk("R11 denied wr_en", {63'd0, wr_en}, 64'd0);

        // R12: read filtering
        defaults(); sel = 12'h43; al = 3'd2; step();
        chk("R12 read selector low", rdo, 64'hBFFF_FFFF_FFFF_FFFF);
        defaults(); sel = 12'h41; step();
        chk("R12 denied read", rdo, 64'd0);

        // R13: one-cycle latency, result follows the request edge
        defaults(); sel = 12'h41;
        @(posedge clk);
        #1; sel = 12'h40;
        chk("R13 before edge holds previous", {62'd0, exc}, 64'd1);
        @(posedge clk); @(negedge clk);
        chk("R13 after edge", {63'd0, grant}, 64'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R13 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule